// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of several numbered localities owns a shared security-device register interface at any moment. Each locality reaches its own copy of an 8-bit access register through a 4 KB window, and the locality number of a transaction is taken from address bits [14:12]. Software in a locality can ask for use of the interface, give it back, or take it by force when it has a higher number than the current owner. The block also keeps a sticky flag that tells a displaced owner it was pushed out.

A handover away from a locality that owns the interface does not complete at once. The block loads the target into a next-locality register and raises an abort request toward the command engine. The move is made only when the engine answers with a one-cycle done pulse. If no locality is active, a request or a seize takes effect on the next clock edge. Writes arrive already decoded as access-register byte writes. Reads are combinational and return the access register of the locality on the address.

Top module: `loc_arbiter`

## Requirements
- R1: After reset every access register reads 0x80 with bit 0 equal to the inverse of est_i. active_loc_o, next_loc_o and abort_loc_o read 0xFF (no locality), and abort_req_o is 0.
- R2: The locality is addr_i[14:12]. For locality values 5 to 7, writes have no effect and reads return 0xFF.
- R3: A write with bit 1 (request-use) set from a locality that is not the owner makes that locality active on the next edge if no locality is active. Its register then reads with bit 5 (active) set.
- R4: If another locality is active, request-use only sets bit 1 of the writer's register. Bit 2 (pending-request) reads 1 for a locality exactly when some other locality has bit 1 set.
- R5: When the owner writes 1 to bit 5 and no locality has request-use set, no locality is active after the edge, and no locality-changed pulse is raised.
- R6: When the owner writes 1 to bit 5 and some locality has request-use set, next_loc_o becomes the highest-numbered such locality and abort_loc_o becomes the owner. abort_req_o stays 1 until an abort_done_i pulse. On that pulse the target becomes active, and the old owner loses both its active bit and its request-use bit.
- R7: A locality that is not the owner and writes 1 to bit 5 clears only its own request-use bit. Ownership does not change.
- R8: A write with bit 3 (seize) set is accepted only if no locality is active, or if the writer's number is above the owner's. It is refused when the writer or any higher locality already has a seize waiting. An accepted seize cancels the waiting seizes of lower localities and retargets next_loc_o. With no owner it takes effect at once.
- R9: On a seize handover the old owner loses its active bit and gains bit 4 (been-seized). Its request-use is kept. The new owner reads active set, with request-use cleared.
- R10: Bit 3 always reads 0. In a write with bit 3 set, bits 1 and 5 are ignored.
- R11: Writing 1 to bit 4 clears the writer's been-seized flag.
- R12: Writes tagged with locality 4 change no state.
- R13: While a handover waits for abort_done_i, a release write by the owner is ignored and next_loc_o holds.
- R14: loc_chg_o is a one-cycle pulse in the first cycle in which active_loc_o shows a newly active valid locality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| wr_en_i | input | 1 | decoded access-register byte write strobe |
| addr_i | input | 15 | address; bits [14:12] give the locality |
| wdata_i | input | 8 | write data byte |
| est_i | input | 1 | establishment flag from the device; bit 0 reads its inverse |
| abort_done_i | input | 1 | command engine finished the requested abort (pulse) |
| rdata_o | output | 8 | access register of the addressed locality |
| active_loc_o | output | 8 | owning locality, 0xFF for none |
| next_loc_o | output | 8 | handover target while an abort is pending, else 0xFF |
| abort_loc_o | output | 8 | locality whose command must be aborted, else 0xFF |
| abort_req_o | output | 1 | handover waiting for abort_done_i |
| loc_chg_o | output | 1 | locality-changed event toward the new owner |

## Verification
The bench builds the block with its default parameters: five localities, locality 4 reserved for hardware, and a 3-bit locality field at address bit 12. With five localities, a three-deep seize chain can be set up (owner 0, seizers 2 and 3), along with a lower refused seize (1) and the hardware-only locality. The 3-bit field also reaches the invalid values 5 to 7. The directed sequences hold handovers open for several cycles before abort_done_i, to show that next_loc_o is retargeted or holds.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int unsigned ID_W = 8;
  localparam logic [ID_W-1:0] LOC_NONE = 8'hFF;

  localparam int unsigned B_VALID  = 7;
  localparam int unsigned B_ACT    = 5;
  localparam int unsigned B_SEIZED = 4;
  localparam int unsigned B_SEIZE  = 3;
  localparam int unsigned B_PEND   = 2;
  localparam int unsigned B_REQ    = 1;
  localparam int unsigned B_EST    = 0;

  typedef struct packed {
    logic req;
    logic seize;
    logic seized;
  } loc_flags_t;

  typedef struct packed {
    logic set_req;
    logic clr_req;
    logic set_seize;
    logic clr_seize;
    logic set_seized;
    logic clr_seized;
  } flag_cmd_t;
endpackage

// File: rtl/loc_flag_slice.sv
module loc_flag_slice
  import loc_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  flag_cmd_t  cmd_i,
  output loc_flags_t flags_o
);
  loc_flags_t q;

  // clear wins over set on each flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (cmd_i.clr_req)         q.req <= 1'b0;
      else if (cmd_i.set_req)    q.req <= 1'b1;
      if (cmd_i.clr_seize)       q.seize <= 1'b0;
      else if (cmd_i.set_seize)  q.seize <= 1'b1;
      if (cmd_i.clr_seized)      q.seized <= 1'b0;
      else if (cmd_i.set_seized) q.seized <= 1'b1;
    end
  end

  assign flags_o = q;

  a_r11_seized_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.clr_seized |=> !flags_o.seized);
endmodule

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
  parameter int unsigned N   = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // ascending scan, last hit wins -> highest number
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/loc_handover_ctl.sv
module loc_handover_ctl
  import loc_arb_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [ID_W-1:0] start_tgt_i,
  input  logic            commit_i,
  input  logic [ID_W-1:0] commit_tgt_i,
  output logic [ID_W-1:0] active_o,
  output logic [ID_W-1:0] next_o,
  output logic [ID_W-1:0] abort_o,
  output logic            pending_o
);
  logic [ID_W-1:0] active_q, next_q, abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= LOC_NONE;
      next_q   <= LOC_NONE;
      abort_q  <= LOC_NONE;
    end else if (commit_i) begin
      active_q <= commit_tgt_i;
      next_q   <= LOC_NONE;
      abort_q  <= LOC_NONE;
    end else if (start_i) begin
      next_q  <= start_tgt_i;
      abort_q <= active_q;
    end
  end

  assign active_o  = active_q;
  assign next_o    = next_q;
  assign abort_o   = abort_q;
  assign pending_o = (next_q != LOC_NONE);

  a_r6_pending_has_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> (active_q < ID_W'(N)) && (abort_q == active_q));
  a_r13_next_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !start_i && !commit_i) |=> $stable(next_q));
  a_r1_ids_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q < ID_W'(N)) || (active_q == LOC_NONE));
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned HW_LOC  = 4,
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned LOC_LSB = 12,
  parameter int unsigned LOC_FW  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              est_i,
  input  logic              abort_done_i,
  output logic [7:0]        rdata_o,
  output logic [ID_W-1:0]   active_loc_o,
  output logic [ID_W-1:0]   next_loc_o,
  output logic [ID_W-1:0]   abort_loc_o,
  output logic              abort_req_o,
  output logic              loc_chg_o
);
  localparam int unsigned IW = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;

  logic [LOC_FW-1:0] loc_f;
  logic [ID_W-1:0]   loc_id, active, next_id, abort_id;
  logic              pending, loc_ok, act_valid, is_owner, wr_ok;
  logic              w_seize, w_act, w_req, w_clrbs, seize_ok, higher_seize;
  logic [NUM_LOC-1:0] req_vec, seize_vec;
  logic              pick_v;
  logic [IW-1:0]     pick_idx;
  logic              start, commit, chg_d, chg_q, tgt_seize;
  logic [ID_W-1:0]   start_tgt, commit_tgt;
  flag_cmd_t         cmd   [NUM_LOC];
  loc_flags_t        flags [NUM_LOC];

  assign loc_f     = addr_i[LOC_LSB +: LOC_FW];
  assign loc_id    = ID_W'(loc_f);
  assign loc_ok    = loc_id < ID_W'(NUM_LOC);
  assign act_valid = active < ID_W'(NUM_LOC);
  assign is_owner  = act_valid && (active == loc_id);
  assign wr_ok     = wr_en_i && loc_ok && (loc_id != ID_W'(HW_LOC));

  // a seize write drops the request and release bits
  assign w_seize = wdata_i[B_SEIZE];
  assign w_act   = wdata_i[B_ACT] & ~w_seize;
  assign w_req   = wdata_i[B_REQ] & ~w_seize;
  assign w_clrbs = wdata_i[B_SEIZED];

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    loc_flag_slice u_slice (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd[g]),
      .flags_o(flags[g])
    );
    assign req_vec[g]   = flags[g].req;
    assign seize_vec[g] = flags[g].seize;
  end

  loc_prio_pick #(.N(NUM_LOC)) u_pick (
    .req_i  (req_vec),
    .valid_o(pick_v),
    .idx_o  (pick_idx)
  );

  loc_handover_ctl #(.N(NUM_LOC)) u_hand (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_tgt_i (start_tgt),
    .commit_i    (commit),
    .commit_tgt_i(commit_tgt),
    .active_o    (active),
    .next_o      (next_id),
    .abort_o     (abort_id),
    .pending_o   (pending)
  );

  always_comb begin
    higher_seize = 1'b0;
    for (int l = 0; l < NUM_LOC; l++) begin
      if (ID_W'(l) > loc_id && seize_vec[l]) higher_seize = 1'b1;
    end
  end

  always_comb begin
    seize_ok = 1'b0;
    if (wr_ok && w_seize && (!act_valid || loc_id > active)) begin
      seize_ok = !higher_seize;
      for (int l = 0; l < NUM_LOC; l++) begin
        if (ID_W'(l) == loc_id && seize_vec[l]) seize_ok = 1'b0;
      end
    end
  end

  always_comb begin
    for (int l = 0; l < NUM_LOC; l++) cmd[l] = '0;
    start      = 1'b0;
    start_tgt  = LOC_NONE;
    commit     = 1'b0;
    commit_tgt = LOC_NONE;
    tgt_seize  = 1'b0;
    chg_d      = 1'b0;

    if (wr_ok) begin
      if (w_act) begin
        if (is_owner) begin
          if (!pending) begin
            if (pick_v) begin
              start     = 1'b1;
              start_tgt = ID_W'(pick_idx);
            end else begin
              commit     = 1'b1;
              commit_tgt = LOC_NONE;
            end
          end
        end else begin
          for (int l = 0; l < NUM_LOC; l++)
            if (ID_W'(l) == loc_id) cmd[l].clr_req = 1'b1;
        end
      end
      if (w_clrbs) begin
        for (int l = 0; l < NUM_LOC; l++)
          if (ID_W'(l) == loc_id) cmd[l].clr_seized = 1'b1;
      end
      if (seize_ok) begin
        for (int l = 0; l < NUM_LOC; l++) begin
          if (ID_W'(l) < loc_id)  cmd[l].clr_seize = 1'b1;
          if (ID_W'(l) == loc_id) cmd[l].set_seize = 1'b1;
        end
        if (act_valid) begin
          start     = 1'b1;
          start_tgt = loc_id;
        end else begin
          commit     = 1'b1;
          commit_tgt = loc_id;
        end
      end
      if (w_req && !is_owner) begin
        if (act_valid) begin
          for (int l = 0; l < NUM_LOC; l++) begin
            if (ID_W'(l) == loc_id) begin
              cmd[l].set_req = 1'b1;
              cmd[l].clr_req = 1'b0;
            end
          end
        end else begin
          commit     = 1'b1;
          commit_tgt = loc_id;
        end
      end
    end

    if (pending && abort_done_i) begin
      start      = 1'b0;
      commit     = 1'b1;
      commit_tgt = next_id;
    end

    // ownership move: update old and new owner flags
    if (commit && commit_tgt != active) begin
      if (act_valid) begin
        for (int l = 0; l < NUM_LOC; l++)
          if (ID_W'(l) == commit_tgt && seize_vec[l]) tgt_seize = 1'b1;
        for (int l = 0; l < NUM_LOC; l++) begin
          if (ID_W'(l) == active) begin
            if (tgt_seize) cmd[l].set_seized = 1'b1;
            else           cmd[l].clr_req    = 1'b1;
          end
        end
      end
      chg_d = commit_tgt < ID_W'(NUM_LOC);
    end
    if (commit) begin
      for (int l = 0; l < NUM_LOC; l++) begin
        if (ID_W'(l) == commit_tgt) begin
          cmd[l].clr_req   = 1'b1;
          cmd[l].set_req   = 1'b0;
          cmd[l].clr_seize = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= 1'b0;
    else         chg_q <= chg_d;
  end

  always_comb begin
    rdata_o = 8'hFF;
    if (loc_ok) begin
      rdata_o = '0;
      rdata_o[B_VALID] = 1'b1;
      rdata_o[B_ACT]   = is_owner;
      rdata_o[B_EST]   = ~est_i;
      for (int l = 0; l < NUM_LOC; l++) begin
        if (ID_W'(l) == loc_id) begin
          rdata_o[B_SEIZED] = flags[l].seized;
          rdata_o[B_REQ]    = flags[l].req;
        end else if (flags[l].req) begin
          rdata_o[B_PEND] = 1'b1;
        end
      end
    end
  end

  assign active_loc_o = active;
  assign next_loc_o   = next_id;
  assign abort_loc_o  = abort_id;
  assign abort_req_o  = pending;
  assign loc_chg_o    = chg_q;

  a_r12_hw_loc_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && loc_id == ID_W'(HW_LOC) && !abort_done_i) |=> $stable(active_loc_o));
  a_r14_chg_has_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_chg_o |-> (active_loc_o < ID_W'(NUM_LOC)));
  a_r14_chg_on_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_chg_o |-> (active_loc_o != $past(active_loc_o)));
  a_r9_owner_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid |-> !(req_vec[active[IW-1:0]]));
  a_r6_done_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_req_o && abort_done_i) |=> (active_loc_o == $past(next_loc_o)) && !abort_req_o);
endmodule

// File: tb/sim_loc_arbiter.sv
module sim_loc_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        est = 1'b1;
  logic        done_p = 1'b0;
  logic [7:0]  rdata, act, nxt, abl;
  logic        areq, chg;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  loc_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .est_i(est), .abort_done_i(done_p),
    .rdata_o(rdata), .active_loc_o(act), .next_loc_o(nxt),
    .abort_loc_o(abl), .abort_req_o(areq), .loc_chg_o(chg)
  );

  task automatic chk(string req, int actual, int expv);
    n_chk++;
    if (actual !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expv);
    end
  endtask

  task automatic wr(int l, logic [7:0] d);
    @(negedge clk);
    addr  = 15'(l << 12);
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int l, output logic [7:0] v);
    addr = 15'(l << 12);
    #1;
    v = rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    done_p = 1'b1;
    @(negedge clk);
    done_p = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int l = 0; l < 5; l++) begin
      rd(l, v);
      chk("R1 reset access", v, 8'h80);
    end
    chk("R1 active none", act, 8'hFF);
    chk("R1 next none", nxt, 8'hFF);
    chk("R1 abort none", abl, 8'hFF);
    chk("R1 abort_req", areq, 0);
    est = 1'b0;
    rd(2, v);
    chk("R1 est bit", v, 8'h81);
    est = 1'b1;
  endtask

  task automatic t_invalid();
    logic [7:0] v;
    wr(5, 8'h02);
    chk("R2 write loc5 ignored", act, 8'hFF);
    wr(7, 8'h08);
    chk("R2 write loc7 ignored", act, 8'hFF);
    rd(6, v);
    chk("R2 read loc6", v, 8'hFF);
  endtask

  task automatic t_request();
    logic [7:0] v;
    wr(1, 8'h02);
    chk("R3 request makes active", act, 1);
    chk("R14 chg pulse", chg, 1);
    @(negedge clk);
    chk("R14 chg one cycle", chg, 0);
    rd(1, v);
    chk("R3 owner reads active", v, 8'hA0);
    wr(3, 8'h02);
    chk("R4 owner unchanged", act, 1);
    rd(3, v);
    chk("R4 req flag set", v, 8'h82);
    rd(1, v);
    chk("R4 owner sees pending", v, 8'hA4);
    wr(0, 8'h02);
    rd(0, v);
    chk("R4 loc0 req and pending", v, 8'h86);
    wr(0, 8'h20);
    rd(0, v);
    chk("R7 nonowner release clears req", v, 8'h84);
    chk("R7 owner unchanged", act, 1);
  endtask

  task automatic t_release();
    logic [7:0] v;
    wr(1, 8'h20);
    chk("R6 abort_req", areq, 1);
    chk("R6 next highest requester", nxt, 3);
    chk("R6 abort loc is owner", abl, 1);
    chk("R6 owner held", act, 1);
    rd(1, v);
    chk("R6 old owner still active", v, 8'hA4);
    wr(1, 8'h20);
    chk("R13 release during wait ignored", nxt, 3);
    repeat (3) @(negedge clk);
    chk("R13 still pending", areq, 1);
    done_pulse();
    chk("R6 commit after done", act, 3);
    chk("R14 chg on commit", chg, 1);
    chk("R6 abort_req cleared", areq, 0);
    rd(1, v);
    chk("R6 old owner cleared", v, 8'h80);
    rd(3, v);
    chk("R6 new owner", v, 8'hA0);
    wr(3, 8'h20);
    chk("R5 release none", act, 8'hFF);
    chk("R5 no chg", chg, 0);
    chk("R5 no abort", areq, 0);
  endtask

  task automatic t_seize();
    logic [7:0] v;
    wr(0, 8'h02);
    chk("R3 loc0 active", act, 0);
    wr(1, 8'h02);
    wr(2, 8'h0A);
    chk("R8 seize accepted", nxt, 2);
    chk("R8 seize waits", act, 0);
    rd(2, v);
    chk("R10 seize reads 0 req ignored", v, 8'h84);
    wr(1, 8'h08);
    chk("R8 refused higher pending", nxt, 2);
    wr(3, 8'h08);
    chk("R8 retarget higher", nxt, 3);
    done_pulse();
    chk("R9 seizer active", act, 3);
    chk("R14 chg seize", chg, 1);
    rd(0, v);
    chk("R9 old owner seized", v, 8'h94);
    rd(3, v);
    chk("R9 new owner", v, 8'hA4);
    rd(1, v);
    chk("R9 requester kept", v, 8'h82);
    wr(1, 8'h08);
    chk("R8 lower seize refused", areq, 0);
    chk("R8 lower seize owner", act, 3);
    wr(0, 8'h10);
    rd(0, v);
    chk("R11 seized cleared", v, 8'h84);
  endtask

  task automatic t_hwloc();
    logic [7:0] v;
    wr(3, 8'h20);
    chk("R6 release to requester", nxt, 1);
    done_pulse();
    chk("R6 loc1 active", act, 1);
    wr(1, 8'h20);
    chk("R5 none active", act, 8'hFF);
    wr(4, 8'h02);
    chk("R12 loc4 request ignored", act, 8'hFF);
    wr(4, 8'h08);
    chk("R12 loc4 seize ignored", act, 8'hFF);
    rd(4, v);
    chk("R12 loc4 register", v, 8'h80);
    wr(2, 8'h08);
    chk("R8 seize with no owner", act, 2);
    chk("R8 no abort needed", areq, 0);
    chk("R14 chg immediate seize", chg, 1);
    rd(2, v);
    chk("R9 seizer reads", v, 8'hA0);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid();
    t_request();
    t_release();
    t_seize();
    t_hwloc();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule